// File: doc/BRIEF.md
# AC'97 Link Frame Controller

This block is the controller end of an AC'97 serial link. On every bit clock it sends one bit of a fixed 256-bit frame and receives one bit of the codec's reply. Each frame has a 16-bit tag slot followed by twelve 20-bit data slots. The controller always generates the frame-sync line itself. A parallel port supplies the outgoing tag and slot words. A second parallel port presents everything received in one frame at once, together with a one-cycle frame-done strobe.

A width-mode input selects 20-bit samples or 16-bit samples. In 16-bit mode each sample is packed into the top of its slot, and the four low bits are padded with zeros. The frame layout cannot be changed. All timing comes from the bit clock alone.

Top module: `ac97_link_ctrl`

## Requirements
- R1: Every frame lasts exactly 256 bit clocks and holds 13 slots, so sync rises once every 256 cycles.
- R2: Slot 0 carries the tag, 16 bits, sent starting from bit 15. Slots 1 to 12 carry 20 bits each, sent starting from bit 19. Each bit is launched on a rising bit-clock edge. Slot k comes from `tx_slots_i[(k-1)*20 +: 20]`.
- R3: Tag bit 2 always goes out as 0, whatever value is on `tx_tag_i[2]`.
- R4: Sync is high for the 16 cycles of the tag slot and low for the other 240 cycles. This block always drives it.
- R5: With `width16_i`=1 (16-bit mode), slot bits 19..4 carry input word bits 15..0, and slot bits 3..0 are sent as 0. With `width16_i`=0, all 20 bits of the word are sent unchanged.
- R6: `sdata_in_i` is sampled on the falling edge, in the same bit position as the bit just launched. The received tag appears on `rx_tag_o`. Slot k appears on `rx_slots_o[(k-1)*20 +: 20]`: as received in 20-bit mode, or as `{4'b0, slot bits 19..4}` in 16-bit mode. The mode used is the one that frame was sent with.
- R7: The tag, the slot words and `width16_i` are captured only at the edge that launches the last bit of a frame, and on every reset edge. Changes at any other time have no effect on the frame being sent.
- R8: `rx_frame_done_o` pulses for one cycle, starting at the rising edge after the last bit of slot 12 is sampled. All received outputs update at that same edge and hold until the next pulse.
- R9: While reset is high, sync, serial data out, the frame-done strobe and the received outputs are 0. The first rising edge after reset launches tag bit 15 with sync high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| width16_i | input | 1 | 1 = 16-bit samples, 0 = 20-bit samples |
| tx_tag_i | input | 16 | Outgoing tag word |
| tx_slots_i | input | 240 | Outgoing slot words 1..12, 20 bits each |
| sdata_out_o | output | 1 | Serial data to the codec |
| sync_o | output | 1 | Frame sync |
| sdata_in_i | input | 1 | Serial data from the codec |
| rx_tag_o | output | 16 | Received tag word |
| rx_slots_o | output | 240 | Received slot words 1..12, 20 bits each |
| rx_frame_done_o | output | 1 | One-cycle strobe when a received frame is published |

## Verification
The assertions assume that reset is held for at least one rising edge before the link runs. They also assume that `sdata_in_i` is stable around each falling edge. The bench's codec model meets both: it holds reset for several cycles, and it changes serial input only at rising edges. The parallel inputs and the width mode change a few nanoseconds after a rising edge, at arbitrary points inside frames. This tests the capture rule while never coinciding with an edge the block samples on. One reset is applied in the middle of a frame, to check the restart behaviour.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;

   localparam int unsigned DEF_TAG_W    = 16;
   localparam int unsigned DEF_SLOT_W   = 20;
   localparam int unsigned DEF_N_DATA   = 12;
   localparam int unsigned DEF_NARROW_W = 16;
   localparam int unsigned DEF_RSVD_BIT = 2;

   typedef enum logic {
      WIDTH_20 = 1'b0,
      WIDTH_16 = 1'b1
   } sample_width_e;

   function automatic int unsigned frame_len(input int unsigned tag_w,
                                             input int unsigned slot_w,
                                             input int unsigned n_data);
      return tag_w + slot_w * n_data;
   endfunction

endpackage

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer #(
   parameter int unsigned TAG_W  = 16,
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned N_DATA = 12,
   parameter int unsigned SIW    = 4,
   parameter int unsigned BIW    = 5
) (
   input  logic           clk_i,
   input  logic           rst_i,
   output logic [SIW-1:0] pos_slot_o,
   output logic [BIW-1:0] pos_bit_o,
   output logic [SIW-1:0] nxt_slot_o,
   output logic [BIW-1:0] nxt_bit_o,
   output logic           pos_last_o,
   output logic           nxt_last_o,
   output logic           sync_o,
   output logic           active_o
);

   localparam logic [SIW-1:0] LAST_SLOT = SIW'(N_DATA);
   localparam logic [BIW-1:0] TAG_MSB   = BIW'(TAG_W - 1);
   localparam logic [BIW-1:0] SLOT_MSB  = BIW'(SLOT_W - 1);

   logic [SIW-1:0] slot_q, slot_n;
   logic [BIW-1:0] bit_q, bit_n;
   logic           sync_q, active_q;

   // next bit position in the frame, counted down within each slot
   always_comb begin
      slot_n = slot_q;
      bit_n  = bit_q - 1'b1;
      if (bit_q == '0) begin
         if (slot_q == LAST_SLOT) begin
            slot_n = '0;
            bit_n  = TAG_MSB;
         end else begin
            slot_n = slot_q + 1'b1;
            bit_n  = SLOT_MSB;
         end
      end
   end

   // reset parks the position on the final bit so the next launch is tag MSB
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         slot_q   <= LAST_SLOT;
         bit_q    <= '0;
         sync_q   <= 1'b0;
         active_q <= 1'b0;
      end else begin
         slot_q   <= slot_n;
         bit_q    <= bit_n;
         sync_q   <= (slot_n == '0);
         active_q <= 1'b1;
      end
   end

   assign pos_slot_o = slot_q;
   assign pos_bit_o  = bit_q;
   assign nxt_slot_o = slot_n;
   assign nxt_bit_o  = bit_n;
   assign pos_last_o = (slot_q == LAST_SLOT) && (bit_q == '0);
   assign nxt_last_o = (slot_n == LAST_SLOT) && (bit_n == '0);
   assign sync_o     = sync_q;
   assign active_o   = active_q;

   assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      slot_q <= LAST_SLOT);

   assert_tag_bits_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (slot_q == '0) |-> (bit_q <= TAG_MSB));

   assert_slot_bits_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      bit_q <= SLOT_MSB);

endmodule

// File: rtl/ac97_tx_framer.sv
module ac97_tx_framer
   import ac97_link_pkg::*;
#(
   parameter int unsigned TAG_W    = 16,
   parameter int unsigned SLOT_W   = 20,
   parameter int unsigned N_DATA   = 12,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned RSVD_BIT = 2,
   parameter int unsigned SIW      = 4,
   parameter int unsigned BIW      = 5
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     load_i,
   input  logic                     width16_i,
   input  logic [TAG_W-1:0]         tag_i,
   input  logic [N_DATA*SLOT_W-1:0] slots_i,
   input  logic [SIW-1:0]           nxt_slot_i,
   input  logic [BIW-1:0]           nxt_bit_i,
   input  logic [SIW-1:0]           pos_slot_i,
   input  logic [BIW-1:0]           pos_bit_i,
   input  logic                     pos_last_i,
   output logic                     sdo_o,
   output logic                     mode_o
);

   localparam int unsigned PAD_W = SLOT_W - NARROW_W;

   logic [N_DATA:0][SLOT_W-1:0] sh_w;
   logic [TAG_W-1:0]            tag_clr;
   logic [TAG_W-1:0]            tag_q;
   logic                        mode_q;
   logic                        sdo_q;

   // reserved tag bit cleared before it reaches the shadow
   always_comb begin
      tag_clr           = tag_i;
      tag_clr[RSVD_BIT] = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (load_i) begin
         tag_q  <= tag_clr;
         mode_q <= width16_i;
      end
   end

   assign sh_w[0] = SLOT_W'(tag_q);

   for (genvar k = 1; k <= N_DATA; k++) begin : g_slot
      logic [SLOT_W-1:0] word_w;
      logic [SLOT_W-1:0] packed_w;
      logic [SLOT_W-1:0] sh_q;

      assign word_w = slots_i[(k-1)*SLOT_W +: SLOT_W];

      if (PAD_W > 0) begin : g_pad
         assign packed_w = (width16_i == WIDTH_16)
                         ? {word_w[NARROW_W-1:0], {PAD_W{1'b0}}}
                         : word_w;
      end else begin : g_nopad
         assign packed_w = word_w;
      end

      always_ff @(posedge clk_i) begin
         if (load_i) sh_q <= packed_w;
      end

      assign sh_w[k] = sh_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) sdo_q <= 1'b0;
      else       sdo_q <= sh_w[nxt_slot_i][nxt_bit_i];
   end

   assign sdo_o  = sdo_q;
   assign mode_o = mode_q;

   assert_tag_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (pos_slot_i == '0 && pos_bit_i == BIW'(RSVD_BIT)) |-> !sdo_q);

   if (PAD_W > 0) begin : g_pad_chk
      assert_narrow_pad_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
         (mode_q == WIDTH_16 && pos_slot_i != '0 && pos_bit_i < BIW'(PAD_W) && !pos_last_i)
            |-> !sdo_q);
   end

endmodule

// File: rtl/ac97_rx_deframer.sv
module ac97_rx_deframer
   import ac97_link_pkg::*;
#(
   parameter int unsigned TAG_W    = 16,
   parameter int unsigned SLOT_W   = 20,
   parameter int unsigned N_DATA   = 12,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned SIW      = 4,
   parameter int unsigned BIW      = 5
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     sdi_i,
   input  logic [SIW-1:0]           pos_slot_i,
   input  logic [BIW-1:0]           pos_bit_i,
   input  logic                     pos_last_i,
   input  logic                     active_i,
   input  logic                     load_i,
   input  logic                     cur_mode_i,
   output logic [TAG_W-1:0]         tag_o,
   output logic [N_DATA*SLOT_W-1:0] slots_o,
   output logic                     done_o
);

   localparam int unsigned PAD_W = SLOT_W - NARROW_W;

   logic [N_DATA:0][SLOT_W-1:0]  work_q;
   logic [N_DATA*SLOT_W-1:0]     pub_w;
   logic [N_DATA*SLOT_W-1:0]     slots_q;
   logic [TAG_W-1:0]             tag_q;
   logic                         frame_mode_q;
   logic                         done_q;
   logic                         publish;

   // falling-edge capture at the position of the bit just launched
   always_ff @(negedge clk_i) begin
      if (!rst_i) work_q[pos_slot_i][pos_bit_i] <= sdi_i;
   end

   // mode of the frame now arriving: previous shadow value at each load
   always_ff @(posedge clk_i) begin
      if (load_i) frame_mode_q <= cur_mode_i;
   end

   for (genvar k = 1; k <= N_DATA; k++) begin : g_unpack
      if (PAD_W > 0) begin : g_pad
         assign pub_w[(k-1)*SLOT_W +: SLOT_W] = (frame_mode_q == WIDTH_16)
            ? {{PAD_W{1'b0}}, work_q[k][SLOT_W-1:PAD_W]}
            : work_q[k];
      end else begin : g_nopad
         assign pub_w[(k-1)*SLOT_W +: SLOT_W] = work_q[k];
      end
   end

   assign publish = pos_last_i && active_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tag_q   <= '0;
         slots_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= publish;
         if (publish) begin
            tag_q   <= work_q[0][TAG_W-1:0];
            slots_q <= pub_w;
         end
      end
   end

   assign tag_o   = tag_q;
   assign slots_o = slots_q;
   assign done_o  = done_q;

   assert_done_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |=> !done_q);

endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
   import ac97_link_pkg::*;
#(
   parameter int unsigned TAG_W    = DEF_TAG_W,
   parameter int unsigned SLOT_W   = DEF_SLOT_W,
   parameter int unsigned N_DATA   = DEF_N_DATA,
   parameter int unsigned NARROW_W = DEF_NARROW_W,
   parameter int unsigned RSVD_BIT = DEF_RSVD_BIT
) (
   input  logic                     bit_clk_i,
   input  logic                     rst_i,
   input  logic                     width16_i,
   input  logic [TAG_W-1:0]         tx_tag_i,
   input  logic [N_DATA*SLOT_W-1:0] tx_slots_i,
   output logic                     sdata_out_o,
   output logic                     sync_o,
   input  logic                     sdata_in_i,
   output logic [TAG_W-1:0]         rx_tag_o,
   output logic [N_DATA*SLOT_W-1:0] rx_slots_o,
   output logic                     rx_frame_done_o
);

   localparam int unsigned FRAME_LEN = frame_len(TAG_W, SLOT_W, N_DATA);
   localparam int unsigned SIW       = $clog2(N_DATA + 1);
   localparam int unsigned BIW       = $clog2((SLOT_W > TAG_W) ? SLOT_W : TAG_W);
   localparam int unsigned PER_W     = $clog2(FRAME_LEN + 1) + 1;

   initial begin : elab_checks
      assert (TAG_W < SLOT_W)      else $fatal(1, "tag slot must be narrower than data slot");
      assert (NARROW_W <= SLOT_W)  else $fatal(1, "narrow sample wider than slot");
      assert (RSVD_BIT < TAG_W)    else $fatal(1, "reserved bit outside tag");
      assert (N_DATA >= 1)         else $fatal(1, "at least one data slot required");
   end

   logic [SIW-1:0] pos_slot, nxt_slot;
   logic [BIW-1:0] pos_bit, nxt_bit;
   logic           pos_last, nxt_last, active;
   logic           load;
   logic           cur_mode;

   assign load = rst_i || nxt_last;

   ac97_frame_timer #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA), .SIW(SIW), .BIW(BIW)
   ) u_timer (
      .clk_i      (bit_clk_i),
      .rst_i      (rst_i),
      .pos_slot_o (pos_slot),
      .pos_bit_o  (pos_bit),
      .nxt_slot_o (nxt_slot),
      .nxt_bit_o  (nxt_bit),
      .pos_last_o (pos_last),
      .nxt_last_o (nxt_last),
      .sync_o     (sync_o),
      .active_o   (active)
   );

   ac97_tx_framer #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA), .NARROW_W(NARROW_W),
      .RSVD_BIT(RSVD_BIT), .SIW(SIW), .BIW(BIW)
   ) u_tx (
      .clk_i      (bit_clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .width16_i  (width16_i),
      .tag_i      (tx_tag_i),
      .slots_i    (tx_slots_i),
      .nxt_slot_i (nxt_slot),
      .nxt_bit_i  (nxt_bit),
      .pos_slot_i (pos_slot),
      .pos_bit_i  (pos_bit),
      .pos_last_i (pos_last),
      .sdo_o      (sdata_out_o),
      .mode_o     (cur_mode)
   );

   ac97_rx_deframer #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA), .NARROW_W(NARROW_W),
      .SIW(SIW), .BIW(BIW)
   ) u_rx (
      .clk_i      (bit_clk_i),
      .rst_i      (rst_i),
      .sdi_i      (sdata_in_i),
      .pos_slot_i (pos_slot),
      .pos_bit_i  (pos_bit),
      .pos_last_i (pos_last),
      .active_i   (active),
      .load_i     (load),
      .cur_mode_i (cur_mode),
      .tag_o      (rx_tag_o),
      .slots_o    (rx_slots_o),
      .done_o     (rx_frame_done_o)
   );

   // sync period watch: cycles since the last observed rise
   logic [PER_W-1:0] per_q;
   logic             sync_d, seen_q;

   always_ff @(posedge bit_clk_i) begin
      if (rst_i) begin
         per_q  <= '0;
         sync_d <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         sync_d <= sync_o;
         if (sync_o && !sync_d) begin
            per_q  <= PER_W'(1);
            seen_q <= 1'b1;
         end else begin
            per_q <= per_q + 1'b1;
         end
      end
   end

   assert_frame_period_R1: assert property (@(posedge bit_clk_i) disable iff (rst_i)
      (sync_o && !sync_d && seen_q) |-> (per_q == PER_W'(FRAME_LEN)));

   assert_sync_in_tag_slot_R4: assert property (@(posedge bit_clk_i) disable iff (rst_i)
      sync_o == (pos_slot == '0));

   assert_done_at_frame_start_R8: assert property (@(posedge bit_clk_i) disable iff (rst_i)
      rx_frame_done_o |-> (sync_o && pos_slot == '0 && pos_bit == BIW'(TAG_W - 1)));

   assert_rx_hold_R8: assert property (@(posedge bit_clk_i) disable iff (rst_i)
      (!$stable(rx_tag_o) && !$past(rst_i)) |-> rx_frame_done_o);

   assert_reset_quiet_R9: assert property (@(posedge bit_clk_i)
      rst_i |=> (!sync_o && !sdata_out_o && !rx_frame_done_o));

endmodule

// File: tb/ac97_link_ctrl_tb.sv
module ac97_link_ctrl_tb;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         w16 = 1'b0;
   logic         sdi = 1'b0;
   logic [15:0]  tag = 16'h0;
   logic [239:0] slots = '0;

   logic         sdo, sync, done;
   logic [15:0]  rtag;
   logic [239:0] rslots;

   always #5 clk = ~clk;   // 100 MHz

   ac97_link_ctrl u_dut (
      .bit_clk_i       (clk),
      .rst_i           (rst),
      .width16_i       (w16),
      .tx_tag_i        (tag),
      .tx_slots_i      (slots),
      .sdata_out_o     (sdo),
      .sync_o          (sync),
      .sdata_in_i      (sdi),
      .rx_tag_o        (rtag),
      .rx_slots_o      (rslots),
      .rx_frame_done_o (done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state
   int           npos = 0;
   int           launched = 0;
   bit           active = 0;
   bit           in_rst = 1;
   bit           cur_w16 = 0;
   bit           lw16 = 0;
   bit           fbits [256];
   bit           cbits [256];
   logic [15:0]  pend_tag = '0, exp_tag = '0;
   logic [239:0] pend_sl = '0, exp_sl = '0;
   bit           exp_sync = 0, exp_sdo = 0, exp_done = 0;

   task automatic load_frame();
      cur_w16 = w16;
      for (int p = 0; p < 16; p++) fbits[p] = (p == 13) ? 1'b0 : tag[15-p];
      for (int k = 0; k < 12; k++) begin
         logic [19:0] word, pk;
         word = slots[k*20 +: 20];
         pk = cur_w16 ? {word[15:0], 4'b0000} : word;
         for (int j = 0; j < 20; j++) fbits[16 + k*20 + j] = pk[19-j];
      end
   endtask

   task automatic regen_codec();
      for (int p = 0; p < 256; p++) cbits[p] = 1'($urandom);
   endtask

   task automatic capture_rx();
      for (int p = 0; p < 16; p++) pend_tag[15-p] = cbits[p];
      for (int k = 0; k < 12; k++) begin
         logic [19:0] raw;
         for (int j = 0; j < 20; j++) raw[19-j] = cbits[16 + k*20 + j];
         pend_sl[k*20 +: 20] = cur_w16 ? {4'b0000, raw[19:4]} : raw;
      end
   endtask

   always @(posedge clk) begin
      in_rst = rst;
      if (rst) begin
         load_frame();
         regen_codec();
         npos = 0; active = 0;
         exp_sync = 0; exp_sdo = 0; exp_done = 0;
         exp_tag = '0; exp_sl = '0;
         sdi = 1'b0;
      end else begin
         exp_done = 0;
         if (npos == 0 && active) begin
            exp_done = 1; exp_tag = pend_tag; exp_sl = pend_sl;
         end
         exp_sync = (npos < 16);
         exp_sdo  = fbits[npos];
         sdi      = cbits[npos];
         launched = npos;
         lw16     = cur_w16;
         active   = 1;
         if (npos == 255) begin
            capture_rx();
            load_frame();   // R7: inputs taken only here
            regen_codec();
         end
         npos = (npos + 1) % 256;
      end
   end

   task automatic check(input bit ok, input string req,
                        input logic [239:0] act, input logic [239:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   bit prev_sync = 0;
   bit seen_rise = 0;
   int per = 0;

   always @(posedge clk) begin
      string rq;
      #2;
      if (in_rst) begin
         check(sync === 1'b0 && sdo === 1'b0 && done === 1'b0, "R9 outputs in reset",
               240'({sync, sdo, done}), 240'(0));
         check(rtag === 16'h0 && rslots === '0, "R9 rx in reset", rslots, 240'(0));
         seen_rise = 0; prev_sync = 0; per = 0;
      end else begin
         check(sync === exp_sync, "R4 sync", 240'(sync), 240'(exp_sync));
         if (launched == 13) rq = "R3 reserved tag bit";
         else if (launched >= 16 && lw16 && ((launched - 16) % 20) >= 16) rq = "R5 pad bit";
         else rq = "R2/R7 data bit";
         check(sdo === exp_sdo, rq, 240'(sdo), 240'(exp_sdo));
         check(done === exp_done, "R8 frame done", 240'(done), 240'(exp_done));
         rq = exp_done ? "R6 rx words" : "R8 rx hold";
         check(rtag === exp_tag, rq, 240'(rtag), 240'(exp_tag));
         check(rslots === exp_sl, rq, rslots, exp_sl);
         per++;
         if (sync && !prev_sync) begin
            if (seen_rise) check(per == 256, "R1 frame length", 240'(per), 240'(256));
            seen_rise = 1;
            per = 0;
         end
         prev_sync = sync;
      end
   end

   task automatic tick();
      @(posedge clk); #3;
   endtask

   task automatic randomize_inputs();
      tag = 16'($urandom);
      for (int k = 0; k < 12; k++) slots[k*20 +: 20] = 20'($urandom);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      tag = 16'hFFFF;        // R3: reserved bit set on input
      for (int k = 0; k < 12; k++) slots[k*20 +: 20] = 20'hFFFFF;
      rst = 1'b1;
      repeat (4) tick();
      rst = 1'b0;
      for (int f = 0; f < 8; f++) begin
         for (int c = 0; c < 256; c++) begin
            tick();
            if (c % 61 == 17) randomize_inputs();   // R7: mid-frame changes
            if (c == 100 && (f % 3) == 1) w16 = ~w16;  // R5/R6 mode switch
         end
      end
      repeat (40) tick();
      rst = 1'b1;                                   // R9: mid-frame reset
      w16 = 1'b1;
      tag = 16'hFFFF;
      for (int k = 0; k < 12; k++) slots[k*20 +: 20] = 20'hFFFFF;
      repeat (3) tick();
      rst = 1'b0;
      for (int f = 0; f < 5; f++) begin
         for (int c = 0; c < 256; c++) begin
            tick();
            if (c % 47 == 5) randomize_inputs();
            if (c == 200 && f == 2) w16 = 1'b0;
         end
      end
      repeat (10) tick();
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule